// File: doc/BRIEF.md
# Fast Ethernet Receive Line Decoder

This block turns the symbol stream of a 100 Mb/s twisted-pair receiver into receive nibbles for a MAC. Its input is a three-level line code that has already been sliced and sampled once per recovered-clock cycle. The stages run in a fixed order. A change of line level is turned into an NRZI transition and then into an NRZ bit. The bit is descrambled with an 11-bit additive key generator. The descrambled stream is aligned to 5-bit code groups, and each group is decoded to a 4-bit nibble. Each nibble is presented with a data-valid level, an error flag and a one-cycle strobe, so nibbles arrive at one fifth of the symbol rate.

The descrambler needs no setup. While unlocked, it fills its key register from the received bits on the assumption that the sender is transmitting idle, which is all ones before scrambling. It declares lock once it has seen a long unbroken run of descrambled ones. Group alignment is taken from the start-of-stream delimiter pair. A stream is closed by the end-of-stream delimiter pair. If the line carries no idle for too long, lock is dropped and acquisition starts again.

Top module: `fast_eth_rx_decoder`

## Requirements
- R1: During reset and in the first cycle after it, `lock_o`, `rx_dv_o`, `rx_er_o` and `nib_stb_o` are all 0.
- R2: Each sample of `line_lvl_i` that differs from the previous sample yields a received bit 1, and an unchanged sample yields a 0. This holds whatever 2-bit codes stand for the three levels (zero 2'b00, plus 2'b01, minus 2'b11 or 2'b10).
- R3: The descrambler XORs each received bit with a key bit. The key bit is the XOR of the key bits produced 11 and 9 bits earlier, which is the same 2047-bit sequence the sender uses.
- R4: While unlocked, the key register loads the inverse of each received bit. `lock_o` rises only after LOCK_ONES (30) consecutive descrambled ones. After 25 idle bits it is still 0, and after 65 idle bits it is 1.
- R5: Once locked, the 10-bit pattern 11000 10001 (first bit sent leftmost) sets group alignment. The following groups are delivered in order as nibbles, using the 4B/5B data table (0:11110, 1:01001, 2:10100, 3:10101, 4:01010, 5:01011, 6:01110, 7:01111, 8:10010, 9:10011, A:10110, B:10111, C:11010, D:11011, E:11100, F:11101). `rx_dv_o` rises together with the first nibble strobe.
- R6: The group pair 01101 00111 ends the stream. `rx_dv_o` falls, and neither of those two groups is delivered as a nibble.
- R7: A group that is not in the data table, met while a stream is open, is delivered with `rx_er_o` = 1 for that nibble only. `rx_er_o` is 0 for valid groups and is never 1 while `rx_dv_o` is 0.
- R8: When locked, if no run of LOCK_ONES descrambled ones ends within LOSS_TIMEOUT (2048) bits, `lock_o` falls and `rx_dv_o` falls one cycle later. After 1000 such bits, lock is still held. Lock is later regained from idle.
- R9: Within a stream, `nib_stb_o` pulses once per group, exactly 5 cycles apart, and only while `rx_dv_o` is 1. `rx_nib_o` changes only on a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered symbol clock, one line sample per cycle |
| rst_n | input | 1 | Synchronous active-low reset |
| line_lvl_i | input | 2 | Sliced three-level line code |
| lock_o | output | 1 | Descrambler locked |
| rx_dv_o | output | 1 | Receive data valid (open stream) |
| rx_er_o | output | 1 | Current nibble came from an invalid group |
| rx_nib_o | output | 4 | Decoded receive nibble |
| nib_stb_o | output | 1 | One-cycle pulse when a new nibble is presented |

## Verification
Suppose a symbol is sampled at clock edge k. The descrambled bit and `lock_o` then update at edge k+1, and the aligner outputs update at edge k+2. The decoder holds one group in reserve so that it can recognise the end pair. As a result, a group's nibble strobe comes two edges after the sample of the last symbol of the group that follows it. The bench drives symbols and reads outputs on falling edges. Nibbles are gathered by a falling-edge monitor that also records the cycle of each strobe, so order and spacing are compared after each stream without guessing the exact strobe cycle. Lock and data-valid checks are placed after enough extra bits to cover the two-cycle pipeline, and each check stays clear of the window in which its threshold could legally be crossed.

// File: rtl/fast_eth_rx_pkg.sv
// Package: shared constants, types and the code-group decode function
// for the receive line decoder. Assumes 5-bit code groups, with the
// first transmitted bit in the most significant position.
package fast_eth_rx_pkg;

    localparam int GRP_W  = 5;
    localparam int PAIR_W = 2 * GRP_W;

    // Start-of-stream and end-of-stream delimiter pairs.
    localparam logic [PAIR_W-1:0] START_PAIR = 10'b11000_10001;
    localparam logic [PAIR_W-1:0] END_PAIR   = 10'b01101_00111;

    typedef struct packed {
        logic       ok;
        logic [3:0] nib;
    } grp_dec_t;

    // Maps one code group to a nibble; ok is 0 for any non-data group.
    function automatic grp_dec_t decode_group(input logic [GRP_W-1:0] g);
        grp_dec_t r;
        r.ok = 1'b1;
        case (g)
            5'b11110: r.nib = 4'h0;
            5'b01001: r.nib = 4'h1;
            5'b10100: r.nib = 4'h2;
            5'b10101: r.nib = 4'h3;
            5'b01010: r.nib = 4'h4;
            5'b01011: r.nib = 4'h5;
            5'b01110: r.nib = 4'h6;
            5'b01111: r.nib = 4'h7;
            5'b10010: r.nib = 4'h8;
            5'b10011: r.nib = 4'h9;
            5'b10110: r.nib = 4'hA;
            5'b10111: r.nib = 4'hB;
            5'b11010: r.nib = 4'hC;
            5'b11011: r.nib = 4'hD;
            5'b11100: r.nib = 4'hE;
            5'b11101: r.nib = 4'hF;
            default: begin
                r.ok  = 1'b0;
                r.nib = 4'h0;
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mlt3_bit_recover.sv
// Module: recovers NRZ bits from the sampled three-level line code.
// The first step rebuilds an NRZI level that toggles on every line-level
// change. The second step marks an NRZI transition as 1. Assumes one
// already-sliced sample per clock; the level codes themselves are not
// interpreted, only compared.
module mlt3_bit_recover #(
    parameter int LVL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] lvl_i,
    output logic             nrz_o
);

    logic [LVL_W-1:0] prev_lvl_q;
    logic             nrzi_q;
    logic             nrzi_d1_q;
    logic             lvl_chg;

    assign lvl_chg = (lvl_i != prev_lvl_q);

    // Line code to NRZI: toggle the rebuilt level on each line change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_lvl_q <= '0;
            nrzi_q     <= 1'b0;
        end else begin
            prev_lvl_q <= lvl_i;
            nrzi_q     <= nrzi_q ^ lvl_chg;
        end
    end

    // NRZI to NRZ: keep the previous NRZI level for transition detection.
    always_ff @(posedge clk) begin
        if (!rst_n) nrzi_d1_q <= 1'b0;
        else        nrzi_d1_q <= nrzi_q;
    end

    assign nrz_o = nrzi_q ^ nrzi_d1_q;

endmodule

// File: rtl/rx_descrambler.sv
// Module: additive descrambler with idle-based self-lock and lock-loss
// timeout. While unlocked, the key register is filled with inverted
// received bits, assuming the sender transmits idle (plain ones). Lock is
// declared after LOCK_ONES consecutive descrambled ones. Once locked, the
// key generator runs freely. Lock is dropped when no such run of ones
// completes within LOSS_TIMEOUT bits.
module rx_descrambler #(
    parameter int LFSR_W       = 11,
    parameter int LFSR_TAP     = 9,
    parameter int LOCK_ONES    = 30,
    parameter int LOSS_TIMEOUT = 2048
) (
    input  logic clk,
    input  logic rst_n,
    input  logic nrz_i,
    output logic dbit_o,
    output logic lock_o
);

    localparam int RUN_W   = $clog2(LOCK_ONES + 1);
    localparam int QUIET_W = $clog2(LOSS_TIMEOUT + 1);
    localparam logic [RUN_W-1:0]   RUN_FULL   = RUN_W'(LOCK_ONES);
    localparam logic [QUIET_W-1:0] QUIET_LAST = QUIET_W'(LOSS_TIMEOUT - 1);

    logic [LFSR_W-1:0]  lfsr_q, lfsr_d;
    logic [RUN_W-1:0]   run_q, run_d;
    logic [QUIET_W-1:0] quiet_q, quiet_d;
    logic               locked_q, locked_d;
    logic               dbit_q;
    logic               key;
    logic               dbit;

    assign key  = lfsr_q[LFSR_W-1] ^ lfsr_q[LFSR_TAP-1];
    assign dbit = nrz_i ^ key;

    // Next-state logic: key load or free-run, run-of-ones count, lock timer.
    always_comb begin
        if (!dbit)                run_d = '0;
        else if (run_q == RUN_FULL) run_d = run_q;
        else                      run_d = run_q + 1'b1;

        if (!locked_q) begin
            lfsr_d   = {lfsr_q[LFSR_W-2:0], ~nrz_i};
            locked_d = (run_d == RUN_FULL);
            quiet_d  = '0;
        end else begin
            lfsr_d   = {lfsr_q[LFSR_W-2:0], key};
            locked_d = 1'b1;
            if (run_d == RUN_FULL) begin
                quiet_d = '0;
            end else if (quiet_q == QUIET_LAST) begin
                quiet_d  = '0;
                locked_d = 1'b0;
                run_d    = '0;
            end else begin
                quiet_d = quiet_q + 1'b1;
            end
        end
    end

    // State registers of the descrambler and its lock tracker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lfsr_q   <= '0;
            run_q    <= '0;
            quiet_q  <= '0;
            locked_q <= 1'b0;
            dbit_q   <= 1'b0;
        end else begin
            lfsr_q   <= lfsr_d;
            run_q    <= run_d;
            quiet_q  <= quiet_d;
            locked_q <= locked_d;
            dbit_q   <= dbit;
        end
    end

    assign dbit_o = dbit_q;
    assign lock_o = locked_q;

endmodule

// File: rtl/group_aligner.sv
// Module: code-group alignment, decode and nibble delivery. It searches
// the descrambled stream for the start pair while locked, then cuts
// 5-bit groups. Each group is held for one group period so that the end
// pair can be recognised before its first half is delivered. Assumes one
// descrambled bit per clock.
module group_aligner
    import fast_eth_rx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_i,
    input  logic       lock_i,
    output logic       dv_o,
    output logic       er_o,
    output logic [3:0] nib_o,
    output logic       stb_o
);

    localparam int PH_W = $clog2(GRP_W);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(GRP_W - 1);

    logic [PAIR_W-1:0] win_q;
    logic [PAIR_W-1:0] win_n;
    logic [PH_W-1:0]   ph_q;
    logic              in_frame_q;
    logic [GRP_W-1:0]  pend_q;
    logic              pend_vld_q;
    logic              dv_q, er_q, stb_q;
    logic [3:0]        nib_q;
    grp_dec_t          pend_dec;

    assign win_n    = {win_q[PAIR_W-2:0], bit_i};
    assign pend_dec = decode_group(pend_q);

    // Bit window shift register for delimiter and group extraction.
    always_ff @(posedge clk) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_n;
    end

    // Framing state machine, group hold stage and nibble output registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q       <= '0;
            in_frame_q <= 1'b0;
            pend_q     <= '0;
            pend_vld_q <= 1'b0;
            dv_q       <= 1'b0;
            er_q       <= 1'b0;
            nib_q      <= '0;
            stb_q      <= 1'b0;
        end else begin
            stb_q <= 1'b0;
            if (!lock_i) begin
                in_frame_q <= 1'b0;
                pend_vld_q <= 1'b0;
                dv_q       <= 1'b0;
                er_q       <= 1'b0;
            end else if (!in_frame_q) begin
                if (win_n == START_PAIR) begin
                    in_frame_q <= 1'b1;
                    ph_q       <= '0;
                    pend_vld_q <= 1'b0;
                end
            end else if (ph_q == PH_LAST) begin
                ph_q <= '0;
                if (pend_vld_q && ({pend_q, win_n[GRP_W-1:0]} == END_PAIR)) begin
                    in_frame_q <= 1'b0;
                    pend_vld_q <= 1'b0;
                    dv_q       <= 1'b0;
                    er_q       <= 1'b0;
                end else begin
                    if (pend_vld_q) begin
                        dv_q  <= 1'b1;
                        nib_q <= pend_dec.nib;
                        er_q  <= ~pend_dec.ok;
                        stb_q <= 1'b1;
                    end
                    pend_q     <= win_n[GRP_W-1:0];
                    pend_vld_q <= 1'b1;
                end
            end else begin
                ph_q <= ph_q + 1'b1;
            end
        end
    end

    assign dv_o  = dv_q;
    assign er_o  = er_q;
    assign nib_o = nib_q;
    assign stb_o = stb_q;

endmodule

// File: rtl/fast_eth_rx_decoder.sv
// Module: top of the receive line decoder. It chains bit recovery,
// descrambling and group alignment in their fixed order. Assumes the line
// code is already sliced and sampled on the recovered symbol clock.
module fast_eth_rx_decoder #(
    parameter int LVL_W        = 2,
    parameter int LFSR_W       = 11,
    parameter int LFSR_TAP     = 9,
    parameter int LOCK_ONES    = 30,
    parameter int LOSS_TIMEOUT = 2048
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] line_lvl_i,
    output logic             lock_o,
    output logic             rx_dv_o,
    output logic             rx_er_o,
    output logic [3:0]       rx_nib_o,
    output logic             nib_stb_o
);

    logic nrz_bit;
    logic plain_bit;
    logic locked;

    mlt3_bit_recover #(
        .LVL_W (LVL_W)
    ) u_bits (
        .clk   (clk),
        .rst_n (rst_n),
        .lvl_i (line_lvl_i),
        .nrz_o (nrz_bit)
    );

    rx_descrambler #(
        .LFSR_W       (LFSR_W),
        .LFSR_TAP     (LFSR_TAP),
        .LOCK_ONES    (LOCK_ONES),
        .LOSS_TIMEOUT (LOSS_TIMEOUT)
    ) u_descr (
        .clk    (clk),
        .rst_n  (rst_n),
        .nrz_i  (nrz_bit),
        .dbit_o (plain_bit),
        .lock_o (locked)
    );

    group_aligner u_align (
        .clk    (clk),
        .rst_n  (rst_n),
        .bit_i  (plain_bit),
        .lock_i (locked),
        .dv_o   (rx_dv_o),
        .er_o   (rx_er_o),
        .nib_o  (rx_nib_o),
        .stb_o  (nib_stb_o)
    );

    assign lock_o = locked;

endmodule

// File: rtl/fast_eth_rx_decoder_chk.sv
// Checker: timing relations between the decoder's outputs, attached to
// every instance of the top module by the bind below.
module fast_eth_rx_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       lock_o,
    input logic       rx_dv_o,
    input logic       rx_er_o,
    input logic [3:0] rx_nib_o,
    input logic       nib_stb_o
);

    p_dv_drops_unlocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !lock_o |=> !rx_dv_o);

    p_err_inside_stream_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_er_o |-> rx_dv_o);

    p_strobe_inside_stream_r9: assert property (@(posedge clk) disable iff (!rst_n)
        nib_stb_o |-> rx_dv_o);

    p_nibble_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !nib_stb_o |-> $stable(rx_nib_o));

    p_strobe_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        nib_stb_o |=> !nib_stb_o);

    p_dv_opens_with_nibble_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_dv_o) |-> nib_stb_o);

endmodule

bind fast_eth_rx_decoder fast_eth_rx_decoder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lock_o    (lock_o),
    .rx_dv_o   (rx_dv_o),
    .rx_er_o   (rx_er_o),
    .rx_nib_o  (rx_nib_o),
    .nib_stb_o (nib_stb_o)
);

// File: tb/fast_eth_rx_decoder_tb.sv
// Directed bench: a transmit model scrambles and line-codes plain bits,
// and each task checks the decoder's nibbles and flags.
module fast_eth_rx_decoder_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] line_lvl = 2'b00;
    logic       lock_o, rx_dv_o, rx_er_o, nib_stb_o;
    logic [3:0] rx_nib_o;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [10:0] tx_s = 11'h5A5;
    int          lvl_idx = 0;
    logic [1:0]  neg_code = 2'b11;

    int       cap_n = 0;
    logic [3:0] cap_nib [64];
    bit       cap_er [64];
    int       cap_t [64];

    logic [4:0] tx_grp [32];
    logic [3:0] exp_nib [32];
    bit         exp_er [32];

    always #5 clk = ~clk;

    fast_eth_rx_decoder u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_lvl_i (line_lvl),
        .lock_o     (lock_o),
        .rx_dv_o    (rx_dv_o),
        .rx_er_o    (rx_er_o),
        .rx_nib_o   (rx_nib_o),
        .nib_stb_o  (nib_stb_o)
    );

    always @(posedge clk) cyc <= cyc + 1;

    // Nibble monitor on falling edges.
    always @(negedge clk) begin
        if (rst_n && nib_stb_o && cap_n < 64) begin
            cap_nib[cap_n] = rx_nib_o;
            cap_er[cap_n]  = rx_er_o;
            cap_t[cap_n]   = cyc;
            cap_n          = cap_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [1:0] code_of(input int idx);
        case (idx)
            1:       return 2'b01;
            3:       return neg_code;
            default: return 2'b00;
        endcase
    endfunction

    function automatic logic [4:0] enc(input logic [3:0] n);
        case (n)
            4'h0: return 5'b11110; 4'h1: return 5'b01001;
            4'h2: return 5'b10100; 4'h3: return 5'b10101;
            4'h4: return 5'b01010; 4'h5: return 5'b01011;
            4'h6: return 5'b01110; 4'h7: return 5'b01111;
            4'h8: return 5'b10010; 4'h9: return 5'b10011;
            4'hA: return 5'b10110; 4'hB: return 5'b10111;
            4'hC: return 5'b11010; 4'hD: return 5'b11011;
            4'hE: return 5'b11100; default: return 5'b11101;
        endcase
    endfunction

    // Scramble one plain bit with the sender's key and drive its line level.
    task automatic send_bit(input bit b);
        logic key;
        key  = tx_s[10] ^ tx_s[8];
        tx_s = {tx_s[9:0], key};
        if (b ^ key) lvl_idx = (lvl_idx + 1) % 4;
        @(negedge clk);
        line_lvl = code_of(lvl_idx);
    endtask

    task automatic send_idle(input int n);
        for (int i = 0; i < n; i++) send_bit(1'b1);
    endtask

    task automatic send_group(input logic [4:0] g);
        for (int i = 4; i >= 0; i--) send_bit(g[i]);
    endtask

    task automatic hold_line(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Sends one delimited stream of n groups and checks what comes out.
    task automatic run_stream(input int n, input string tag);
        int base;
        base = cap_n;
        send_idle(20);
        send_group(5'b11000);
        send_group(5'b10001);
        for (int i = 0; i < n; i++) send_group(tx_grp[i]);
        send_group(5'b01101);
        send_group(5'b00111);
        send_idle(20);
        chk(cap_n - base == n, {"R6 nibble count ", tag}, cap_n - base, n);
        for (int i = 0; i < n && base + i < cap_n; i++) begin
            chk(cap_nib[base+i] == exp_nib[i], {"R5 nibble value ", tag},
                cap_nib[base+i], exp_nib[i]);
            chk(cap_er[base+i] == exp_er[i], {"R7 error flag ", tag},
                cap_er[base+i], exp_er[i]);
            if (i > 0)
                chk(cap_t[base+i] - cap_t[base+i-1] == 5, {"R9 strobe spacing ", tag},
                    cap_t[base+i] - cap_t[base+i-1], 5);
        end
        chk(rx_dv_o == 1'b0, {"R6 data valid after end pair ", tag}, rx_dv_o, 0);
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk(lock_o == 0 && rx_dv_o == 0 && rx_er_o == 0 && nib_stb_o == 0,
            "R1 outputs in reset", {lock_o, rx_dv_o, rx_er_o, nib_stb_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(lock_o == 0 && rx_dv_o == 0 && rx_er_o == 0 && nib_stb_o == 0,
            "R1 outputs after reset", {lock_o, rx_dv_o, rx_er_o, nib_stb_o}, 0);
    endtask

    task automatic t_acquire;
        hold_line(60);
        chk(lock_o == 0, "R4 no lock on a quiet line", lock_o, 0);
        send_idle(25);
        chk(lock_o == 0, "R4 no lock before the run of ones", lock_o, 0);
        send_idle(40);
        chk(lock_o == 1, "R4 lock after idle", lock_o, 1);
    endtask

    task automatic t_all_nibbles;
        for (int i = 0; i < 18; i++) begin
            exp_nib[i] = (i < 16) ? 4'(i) : ((i == 16) ? 4'h5 : 4'hA);
            exp_er[i]  = 1'b0;
            tx_grp[i]  = enc(exp_nib[i]);
        end
        run_stream(18, "all values (R2 R3)");
    endtask

    task automatic t_alt_codes;
        neg_code = 2'b10;
        exp_nib[0] = 4'h3; exp_nib[1] = 4'hC; exp_nib[2] = 4'h7;
        exp_nib[3] = 4'hE; exp_nib[4] = 4'h1; exp_nib[5] = 4'h8;
        for (int i = 0; i < 6; i++) begin
            exp_er[i] = 1'b0;
            tx_grp[i] = enc(exp_nib[i]);
        end
        run_stream(6, "other minus code (R2)");
        neg_code = 2'b11;
    endtask

    task automatic t_bad_groups;
        tx_grp[0] = enc(4'h2);  exp_nib[0] = 4'h2; exp_er[0] = 1'b0;
        tx_grp[1] = 5'b00000;   exp_nib[1] = 4'h0; exp_er[1] = 1'b1;
        tx_grp[2] = enc(4'h9);  exp_nib[2] = 4'h9; exp_er[2] = 1'b0;
        tx_grp[3] = 5'b11111;   exp_nib[3] = 4'h0; exp_er[3] = 1'b1;
        tx_grp[4] = enc(4'h4);  exp_nib[4] = 4'h4; exp_er[4] = 1'b0;
        run_stream(5, "invalid groups (R7)");
    endtask

    task automatic t_loss;
        send_idle(20);
        send_group(5'b11000);
        send_group(5'b10001);
        for (int i = 0; i < 4; i++) send_group(enc(4'(i + 6)));
        chk(rx_dv_o == 1, "R5 stream open before line goes quiet", rx_dv_o, 1);
        hold_line(1000);
        chk(lock_o == 1, "R8 lock held before timeout", lock_o, 1);
        hold_line(1100);
        chk(lock_o == 0, "R8 lock lost after timeout", lock_o, 0);
        chk(rx_dv_o == 0, "R8 data valid dropped on loss", rx_dv_o, 0);
        send_idle(80);
        chk(lock_o == 1, "R8 lock regained from idle", lock_o, 1);
    endtask

    initial begin : wd
        #1000000;
        errors++;
        $display("FAIL watchdog: actual %0d expected %0d cycles", cyc, 100000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_acquire();
        t_all_nibbles();
        t_alt_codes();
        t_bad_groups();
        t_loss();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule